// File: doc/BRIEF.md
# I2C Master Bit-Timing Engine

This block turns single bus commands from a byte-level controller into correctly timed SCL and SDA waveforms for an I2C master. It takes five timing fields and an idle field. Every field is scaled by one shared power-of-two prescaler. It then builds START, repeated START and STOP conditions and single data bits. SDA is only ever moved while SCL is held low, and only after a programmable data-valid delay. The one exception is the deliberate edges that form a bus condition.

The outputs are open-drain enables: 1 pulls the line low, 0 releases it. The block watches the real line levels on `scl_in` and `sda_in`. The high half of each bit is timed from the moment SCL is actually seen high, so a slave that holds SCL low simply stretches the bit. Received data is captured at that same moment. After reset, and again after every STOP, the block waits for both lines to stay high for a full idle window before it reports the bus free.

Top module: `i2c_bit_engine`

Let P = 2^`cfg_prescale` and T(x) = (x + 1) × P clock cycles.

## Requirements
- R1: While SCL is released in two consecutive cycles, `sda_oe` changes only as part of forming a START, repeated START or STOP.
- R2: During and after reset, `busy` is 1, `cmd_ready` is 0 and both enables are 0. Once both lines have been seen high for T(`cfg_idle`) consecutive clock edges, `busy` drops to 0 and `cmd_ready` rises. While `busy` is 0, both enables stay 0.
- R3: During any idle wait, a clock edge that sees either line low restarts the idle window from zero.
- R4: On a free bus, an accepted START (`cmd_op` = 0) pulls SDA at the accepting edge and pulls SCL T(`cfg_edge_hold`) edges later. `busy` goes to 1 at the accepting edge.
- R5: A WRITE (`cmd_op` = 2) or READ (`cmd_op` = 3) accepted with SCL low sets SDA T(`cfg_data_dly`) edges after acceptance. It releases SCL (`cfg_scl_lo` − `cfg_data_dly`) × P edges after that. It pulls SCL again T(`cfg_scl_hi`) edges after the edge that first sees SCL high. At that same edge `bit_done` pulses for one cycle.
- R6: A WRITE drives `sda_oe` = NOT `cmd_bit`, and a READ releases SDA. For both, `rx_bit` takes the level of `sda_in` at the first edge that sees SCL high, and holds it until the next bit.
- R7: A START accepted while the bus is owned releases SDA after T(`cfg_data_dly`) edges and releases SCL after (`cfg_scl_lo` − `cfg_data_dly`) × P more. Once SCL is seen high, it pulls SDA after T(`cfg_edge_hold`) edges and pulls SCL after T(`cfg_edge_hold`) more.
- R8: A STOP (`cmd_op` = 1) pulls SDA after T(`cfg_data_dly`) edges and releases SCL after (`cfg_scl_lo` − `cfg_data_dly`) × P more. Once SCL is seen high, it releases SDA after T(`cfg_edge_hold`) edges. It then runs the idle wait of R2, and `busy` stays 1 until that wait completes.
- R9: `cmd_ready` is 1 only when the bus is free or owned with SCL low. On a free bus, a command other than START is consumed and has no effect.
- R10: Every count above scales with the prescaler, for prescale exponents both zero and non-zero.
- R11: If SCL is held low externally after release, the block waits, and the high-phase count starts only at the edge that first sees SCL high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_prescale | input | PRE_W | Exponent of the shared prescaler |
| cfg_scl_lo | input | FIELD_W | SCL low period field |
| cfg_scl_hi | input | FIELD_W | SCL high period field |
| cfg_edge_hold | input | FIELD_W | Setup/hold field for bus conditions |
| cfg_data_dly | input | FIELD_W | Data-valid delay field after SCL falls |
| cfg_idle | input | IDLE_W | Minimum bus-idle field |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_bit | input | 1 | Bit value for WRITE |
| cmd_ready | output | 1 | Command taken at the next edge when valid |
| scl_in | input | 1 | Observed SCL level (after filtering) |
| sda_in | input | 1 | Observed SDA level (after filtering) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_bit | output | 1 | SDA level captured at the SCL rise of the last bit |
| bit_done | output | 1 | One-cycle strobe at the end of a bit |
| busy | output | 1 | Bus owned, or idle window not yet complete |

## Verification
The checker assumes that the timing fields meet their minimums. In particular it assumes `cfg_data_dly` < `cfg_scl_lo`, so the remaining low span is never zero or negative. It also assumes the fields change only while the bus is free. The stimulus uses two legal configurations and changes them only while `busy` is low. It models the lines as wired-AND of the block's enables and a bench slave. The slave changes SDA or holds SCL only while SCL is low, or during an idle wait.

// File: rtl/i2c_bit_engine_pkg.sv
// Shared types for the I2C bit-timing engine.
package i2c_bit_engine_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE_WAIT,
        ST_FREE,
        ST_COND_HOLD,
        ST_OWNED,
        ST_DATA_DLY,
        ST_LOW_REST,
        ST_WAIT_RISE,
        ST_HIGH,
        ST_COND_SETUP
    } state_e;

    typedef enum logic [2:0] {
        SP_IDLE,
        SP_EDGE,
        SP_DATA,
        SP_LOREST,
        SP_HIGH
    } span_e;

endpackage

// File: rtl/i2c_bt_span.sv
// Span selector: turns the timing field chosen by the sequencer into the
// last count value of a phase, (base << prescale) - 1.
// Assumes the low field exceeds the data-valid field (checked by software).
module i2c_bt_span
    import i2c_bit_engine_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int IDLE_W  = 12,
    parameter int PRE_W   = 3,
    parameter int CNT_W   = 20
) (
    input  span_e              sel,
    input  logic [PRE_W-1:0]   pre,
    input  logic [FIELD_W-1:0] f_lo,
    input  logic [FIELD_W-1:0] f_hi,
    input  logic [FIELD_W-1:0] f_edge,
    input  logic [FIELD_W-1:0] f_dly,
    input  logic [IDLE_W-1:0]  f_idle,
    output logic [CNT_W-1:0]   last
);
    logic [CNT_W-1:0] base;

    // Unscaled length of the selected phase.
    always_comb begin
        unique case (sel)
            SP_IDLE:   base = CNT_W'(f_idle) + CNT_W'(1);
            SP_EDGE:   base = CNT_W'(f_edge) + CNT_W'(1);
            SP_DATA:   base = CNT_W'(f_dly) + CNT_W'(1);
            SP_LOREST: base = CNT_W'(f_lo) - CNT_W'(f_dly);
            default:   base = CNT_W'(f_hi) + CNT_W'(1);
        endcase
    end

    // Scale by the shared prescaler and convert to a terminal count.
    always_comb last = (base << pre) - CNT_W'(1);
endmodule

// File: rtl/i2c_bt_phase_cnt.sv
// Phase counter: counts clock edges within one sequencer phase and flags the
// cycle in which the terminal count is reached. Restart has priority.
module i2c_bt_phase_cnt #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] last,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    // Count up while running; clear at every phase change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (run && cnt != last) cnt <= cnt + CNT_W'(1);
    end

    // Terminal-count flag for the sequencer.
    always_comb hit = (cnt == last);
endmodule

// File: rtl/i2c_bit_engine.sv
// I2C master bit-timing engine. Sequences START, repeated START, STOP and
// single data bits with prescaled timing, drives open-drain enables and
// samples SDA at the observed SCL rise. Assumes filtered line inputs and
// timing fields held stable while the bus is owned.
module i2c_bit_engine
    import i2c_bit_engine_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int IDLE_W  = 12,
    parameter int PRE_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRE_W-1:0]   cfg_prescale,
    input  logic [FIELD_W-1:0] cfg_scl_lo,
    input  logic [FIELD_W-1:0] cfg_scl_hi,
    input  logic [FIELD_W-1:0] cfg_edge_hold,
    input  logic [FIELD_W-1:0] cfg_data_dly,
    input  logic [IDLE_W-1:0]  cfg_idle,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic               cmd_bit,
    output logic               cmd_ready,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               rx_bit,
    output logic               bit_done,
    output logic               busy
);
    localparam int MAX_SHIFT = (1 << PRE_W) - 1;
    localparam int BASE_W    = ((IDLE_W > FIELD_W) ? IDLE_W : FIELD_W) + 1;
    localparam int CNT_W     = BASE_W + MAX_SHIFT;

    state_e           state, state_d;
    span_e            span_sel;
    op_e              op_q;
    logic             bit_q;
    logic             phase_hit;
    logic             restart;
    logic             timed;
    logic             lines_hi;
    logic             drive_val;
    logic [CNT_W-1:0] span_last;

    assign lines_hi = scl_in && sda_in;

    // Next-state logic and span selection for the active phase.
    always_comb begin
        state_d  = state;
        span_sel = SP_HIGH;
        timed    = 1'b1;
        unique case (state)
            ST_IDLE_WAIT: begin
                span_sel = SP_IDLE;
                if (lines_hi && phase_hit) state_d = ST_FREE;
            end
            ST_FREE: begin
                timed = 1'b0;
                if (cmd_valid && op_e'(cmd_op) == OP_START) state_d = ST_COND_HOLD;
            end
            ST_COND_HOLD: begin
                span_sel = SP_EDGE;
                if (phase_hit) state_d = ST_OWNED;
            end
            ST_OWNED: begin
                timed = 1'b0;
                if (cmd_valid) state_d = ST_DATA_DLY;
            end
            ST_DATA_DLY: begin
                span_sel = SP_DATA;
                if (phase_hit) state_d = ST_LOW_REST;
            end
            ST_LOW_REST: begin
                span_sel = SP_LOREST;
                if (phase_hit) state_d = ST_WAIT_RISE;
            end
            ST_WAIT_RISE: begin
                timed = 1'b0;
                if (scl_in)
                    state_d = (op_q == OP_WRITE || op_q == OP_READ) ? ST_HIGH : ST_COND_SETUP;
            end
            ST_HIGH: begin
                span_sel = SP_HIGH;
                if (phase_hit) state_d = ST_OWNED;
            end
            default: begin
                span_sel = SP_EDGE;
                if (phase_hit) state_d = (op_q == OP_START) ? ST_COND_HOLD : ST_IDLE_WAIT;
            end
        endcase
    end

    // Phase change or a low line during the idle wait restarts the count.
    always_comb restart = (state_d != state) || (state == ST_IDLE_WAIT && !lines_hi);

    // SDA level requested at the end of the data-valid delay.
    always_comb begin
        unique case (op_q)
            OP_START: drive_val = 1'b0;
            OP_STOP:  drive_val = 1'b1;
            OP_WRITE: drive_val = !bit_q;
            default:  drive_val = 1'b0;
        endcase
    end

    i2c_bt_span #(
        .FIELD_W(FIELD_W), .IDLE_W(IDLE_W), .PRE_W(PRE_W), .CNT_W(CNT_W)
    ) u_span (
        .sel(span_sel), .pre(cfg_prescale), .f_lo(cfg_scl_lo), .f_hi(cfg_scl_hi),
        .f_edge(cfg_edge_hold), .f_dly(cfg_data_dly), .f_idle(cfg_idle), .last(span_last)
    );

    i2c_bt_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(timed),
        .last(span_last), .hit(phase_hit)
    );

    // State register and line/strobe updates made on entry to each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE_WAIT;
            op_q     <= OP_START;
            bit_q    <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            rx_bit   <= 1'b0;
            bit_done <= 1'b0;
        end else begin
            state    <= state_d;
            bit_done <= 1'b0;
            if (state_d != state) begin
                unique case (state_d)
                    ST_COND_HOLD: begin
                        sda_oe <= 1'b1;
                        op_q   <= OP_START;
                    end
                    ST_OWNED: begin
                        scl_oe <= 1'b1;
                        if (state == ST_HIGH) bit_done <= 1'b1;
                    end
                    ST_DATA_DLY: begin
                        op_q  <= op_e'(cmd_op);
                        bit_q <= cmd_bit;
                    end
                    ST_LOW_REST:  sda_oe <= drive_val;
                    ST_WAIT_RISE: scl_oe <= 1'b0;
                    ST_HIGH:      rx_bit <= sda_in;
                    ST_IDLE_WAIT: sda_oe <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // Handshake and ownership flags decoded from the state register.
    always_comb begin
        cmd_ready = (state == ST_FREE) || (state == ST_OWNED);
        busy      = (state != ST_FREE);
    end
endmodule

// File: rtl/i2c_bit_engine_chk.sv
// Property checker for the I2C bit-timing engine, attached by bind.
// Assumes legal timing fields; all properties are disabled during reset.
module i2c_bit_engine_chk
    import i2c_bit_engine_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic bit_done,
    input logic cmd_ready,
    input op_e  op_q
);
    AST_SDA_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe))
            |-> (op_q == OP_START || op_q == OP_STOP)); // R1

    AST_FREE_LINES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R2

    AST_COND_EDGE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> busy); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |=> !bit_done); // R5

    AST_DONE_SCL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> (scl_oe && cmd_ready)); // R5

    AST_FREE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cmd_ready); // R9
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
    .bit_done(bit_done), .cmd_ready(cmd_ready), .op_q(op_q)
);

// File: tb/i2c_bit_engine_test.sv
module i2c_bit_engine_test;
    localparam int OPS = 0, OPP = 1, OPW = 2, OPR = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_prescale = 3'd0;
    logic [7:0] cfg_scl_lo = 8'd11, cfg_scl_hi = 8'd5, cfg_edge_hold = 8'd4, cfg_data_dly = 8'd2;
    logic [11:0] cfg_idle = 12'd26;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       cmd_bit = 1'b0;
    logic       slv_scl = 1'b0, slv_sda = 1'b0;
    logic       cmd_ready, scl_oe, sda_oe, rx_bit, bit_done, busy;
    logic       scl_in, sda_in;

    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    assign scl_in = !(scl_oe | slv_scl);
    assign sda_in = !(sda_oe | slv_sda);

    i2c_bit_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_prescale(cfg_prescale), .cfg_scl_lo(cfg_scl_lo),
        .cfg_scl_hi(cfg_scl_hi), .cfg_edge_hold(cfg_edge_hold), .cfg_data_dly(cfg_data_dly),
        .cfg_idle(cfg_idle), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
        .cmd_ready(cmd_ready), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .rx_bit(rx_bit), .bit_done(bit_done), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic  e_scl = 0, e_sda = 0, e_busy = 1, e_ready = 0, e_done = 0, e_rx = 0, m_cond = 0;
    string m_req = "R2";

    function automatic int t_of(input int f);
        return (f + 1) << cfg_prescale;
    endfunction

    function automatic int low_rest();
        return (int'(cfg_scl_lo) - int'(cfg_data_dly)) << cfg_prescale;
    endfunction

    task automatic m_idle();
        int k = 0;
        int n = t_of(int'(cfg_idle));
        while (k < n) begin
            @(posedge clk);
            if (!(e_scl | slv_scl) && !(e_sda | slv_sda)) k++;
            else k = 0;
        end
        e_busy = 0; e_ready = 1; m_cond = 0;
    endtask

    task automatic m_wait_rise();
        @(posedge clk);
        while (slv_scl) @(posedge clk);
    endtask

    task automatic m_front(input logic level);
        e_ready = 0;
        repeat (t_of(int'(cfg_data_dly))) @(posedge clk);
        e_sda = level;
        repeat (low_rest()) @(posedge clk);
        e_scl = 0;
        m_wait_rise();
    endtask

    initial begin : model
        wait (rst_n);
        m_idle();
        forever begin
            @(posedge clk);
            e_done = 0;
            if (cmd_valid && e_ready) begin
                if (!e_busy) begin
                    if (cmd_op == 2'(OPS)) begin
                        m_req = "R4"; e_busy = 1; e_ready = 0; m_cond = 1; e_sda = 1;
                        repeat (t_of(int'(cfg_edge_hold))) @(posedge clk);
                        e_scl = 1; e_ready = 1; m_cond = 0;
                    end else m_req = "R9";
                end else if (cmd_op == 2'(OPS)) begin
                    m_req = "R7"; m_cond = 1;
                    m_front(1'b0);
                    repeat (t_of(int'(cfg_edge_hold))) @(posedge clk);
                    e_sda = 1;
                    repeat (t_of(int'(cfg_edge_hold))) @(posedge clk);
                    e_scl = 1; e_ready = 1; m_cond = 0;
                end else if (cmd_op == 2'(OPP)) begin
                    m_req = "R8"; m_cond = 1;
                    m_front(1'b1);
                    repeat (t_of(int'(cfg_edge_hold))) @(posedge clk);
                    e_sda = 0; m_req = "R3";
                    m_idle();
                end else begin
                    m_req = "R5";
                    m_front((cmd_op == 2'(OPW)) ? !cmd_bit : 1'b0);
                    e_rx = !(e_sda | slv_sda);
                    repeat (t_of(int'(cfg_scl_hi))) @(posedge clk);
                    e_scl = 1; e_done = 1; e_ready = 1;
                end
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    logic prev_scl = 0, prev_sda = 0, have_prev = 0;
    always @(negedge clk) begin
        string tag;
        tag = (cfg_prescale != 0) ? "R10" : m_req;
        check(scl_oe === e_scl, {tag, " scl_oe"}, int'(scl_oe), int'(e_scl));
        check(sda_oe === e_sda, {tag, " sda_oe"}, int'(sda_oe), int'(e_sda));
        check(busy === e_busy, {tag, " busy"}, int'(busy), int'(e_busy));
        check(cmd_ready === e_ready, {"R9 cmd_ready/", tag}, int'(cmd_ready), int'(e_ready));
        check(bit_done === e_done, {tag, " bit_done"}, int'(bit_done), int'(e_done));
        check(rx_bit === e_rx, "R6 rx_bit", int'(rx_bit), int'(e_rx));
        if (rst_n && have_prev && !prev_scl && !scl_oe && sda_oe != prev_sda)
            check(m_cond, "R1 SDA moved with SCL high", int'(sda_oe), int'(prev_sda));
        prev_scl = scl_oe; prev_sda = sda_oe; have_prev = rst_n;
    end

    // ---------------- stimulus ----------------
    task automatic wait_ready();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic issue(input int op, input logic b);
        wait_ready();
        cmd_valid = 1; cmd_op = 2'(op); cmd_bit = b;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_free();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_read(input logic slave_low);
        wait_ready();
        slv_sda = slave_low;
        issue(OPR, 1'b0);
        wait_ready();
        slv_sda = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n = 1;                              // R2 idle wait after reset
        wait_free();
        issue(OPP, 1'b0);                       // R9 STOP on free bus ignored
        issue(OPW, 1'b1);                       // R9 WRITE on free bus ignored
        repeat (5) @(negedge clk);
        issue(OPS, 1'b0);                       // R4
        issue(OPW, 1'b1);                       // R5 R6
        issue(OPW, 1'b0);
        do_read(1'b1);                          // R6 slave drives 0
        do_read(1'b0);                          // R6 line released reads 1
        wait_ready();
        slv_scl = 1;                            // R11 stretch
        issue(OPW, 1'b0);
        repeat (40) @(negedge clk);
        slv_scl = 0;
        issue(OPS, 1'b0);                       // R7 repeated START
        issue(OPW, 1'b1);
        issue(OPP, 1'b0);                       // R8
        repeat (30) @(negedge clk);
        slv_sda = 1;                            // R3 restart idle window
        repeat (3) @(negedge clk);
        slv_sda = 0;
        wait_free();
        cfg_prescale = 3'd2; cfg_scl_lo = 8'd17; cfg_scl_hi = 8'd11;   // R10
        cfg_edge_hold = 8'd7; cfg_data_dly = 8'd3; cfg_idle = 12'd40;
        repeat (3) @(negedge clk);
        issue(OPS, 1'b0);
        issue(OPW, 1'b0);
        do_read(1'b1);
        issue(OPS, 1'b0);
        issue(OPW, 1'b1);
        issue(OPP, 1'b0);
        wait_free();
        repeat (10) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule